// File: doc/BRIEF.md
# Laser Safety Enable Controller

This block decides, one clock at a time, whether the transmit laser of an optical module may emit. Two shutdown requests feed it: a hardware request line from the host, where high or floating means "laser off", and a software request bit written through management access. The two are combined with a logical OR. A third input carries the raw output of a driver fault detector. When that detector reports a fault while the transmitter is active, the block latches the fault, raises the fault flag and forces the laser off. The fault stays latched until the host clears it on purpose.

To clear a fault, the host holds a shutdown request for at least a minimum time and then drops it. The flag falls on the release. The laser then stays dark for a full initialisation period, and after that the normal enable path takes over again. The same initialisation period runs after power becomes good. While power is not good, which covers a module that is not fully seated, the laser is off and the fault flag reads high.

All time limits are counts of a fixed-rate `tick_i` strobe. The defaults assume a 1 µs tick: 10 ticks of hold to clear a fault, 1000 ticks of release before the laser comes on, and 300000 ticks of initialisation. A shutdown request removes the laser enable in the same cycle, with no clock delay.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While `pwr_good_i` is low, and from the clock edge after it goes low, `laser_on_o` is 0, `fault_flag_o` is 1 and `ready_o` is 0. This is also the state out of reset.
- R2: Initialisation starts on the first clock edge that samples `pwr_good_i` high. From that edge `fault_flag_o` is 0. `ready_o` rises on the edge that follows INIT_TICKS counted ticks, and `laser_on_o` stays 0 until then.
- R3: The request line `laser_off_req_i` and the software bit `laser_off_sw_i` are ORed. While either is 1, `laser_on_o` is 0 in the same cycle, with no clock edge in between.
- R4: After both requests are 0, `laser_on_o` returns to 1 only once EN_TICKS ticks have been counted with both still 0. Any request restarts that count.
- R5: A 1 on `drv_fault_i` while running sets `fault_flag_o` to 1 and `laser_on_o` and `ready_o` to 0 on the next edge. This state holds after `drv_fault_i` returns to 0.
- R6: A latched fault clears when a request has been held for at least RST_TICKS ticks and is then released. On the edge after the release `fault_flag_o` is 0. The laser stays off and `ready_o` stays 0 for a full initialisation, and then running resumes.
- R7: A request held for fewer than RST_TICKS ticks before release leaves the fault latched.
- R8: All timers advance only on cycles where `tick_i` is 1. Cycles without a tick do not count toward any limit.
- R9: If `drv_fault_i` is still 1 during the re-initialisation that follows a clear, the fault latches again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fixed-rate time base strobe |
| laser_off_req_i | input | 1 | Host shutdown request line, 1 = laser off |
| laser_off_sw_i | input | 1 | Software shutdown bit, ORed with the line |
| drv_fault_i | input | 1 | Raw driver fault condition |
| pwr_good_i | input | 1 | Supply good and module seated |
| laser_on_o | output | 1 | Laser enable to the driver |
| fault_flag_o | output | 1 | Latched fault, or power not good |
| ready_o | output | 1 | Initialisation complete, no fault |

## Verification
The bench goes after the exact boundaries of every timer.

- **Fault clear hold.** A request held one tick short of RST_TICKS must leave the fault set. A design that compares with an off-by-one would clear the fault here.
- **Laser re-enable.** A release lasting EN_TICKS minus one ticks must keep the laser dark. A design with an off-by-one would turn the laser on one tick early.
- **Initialisation length.** The bench checks the last cycle before `ready_o` rises and then the cycle it rises, both after power-up and after a fault clear. A design that restored the laser straight after a clear fails here.
- **Tick gating.** Long stretches without a tick catch a design that counts clocks instead of ticks.
- **Sticky fault.** A raw fault still present during re-initialisation catches a design that clears the fault for good.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INIT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_FAULT  = 3'd3,
    ST_REINIT = 3'd4
  } lsr_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/lsr_tick_timer.sv
module lsr_tick_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = lsr_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == LIM);

  // saturating count of ticks since last clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lsr_ctrl_fsm.sv
module lsr_ctrl_fsm
  import lsr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       off_req_i,
  input  logic       fault_raw_i,
  input  logic       init_done_i,
  input  logic       hold_done_i,
  output lsr_state_e state_o
);
  lsr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_INIT;
        ST_INIT,
        ST_REINIT: begin
          if (fault_raw_i)      state_d = ST_FAULT;
          else if (init_done_i) state_d = ST_RUN;
        end
        ST_RUN:    if (fault_raw_i) state_d = ST_FAULT;
        // hold_done_i still reflects the hold on the first released cycle
        ST_FAULT:  if (!off_req_i && hold_done_i) state_d = ST_REINIT;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
  import lsr_pkg::*;
#(
  parameter int unsigned RST_TICKS  = 10,
  parameter int unsigned EN_TICKS   = 1000,
  parameter int unsigned INIT_TICKS = 300000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic laser_off_req_i,
  input  logic laser_off_sw_i,
  input  logic drv_fault_i,
  input  logic pwr_good_i,
  output logic laser_on_o,
  output logic fault_flag_o,
  output logic ready_o
);
  logic       off_req;
  logic       en_done, hold_done, init_done;
  logic       in_init;
  lsr_state_e state;

  assign off_req = laser_off_req_i | laser_off_sw_i;
  assign in_init = (state == ST_INIT) || (state == ST_REINIT);

  lsr_tick_timer #(.LIMIT(EN_TICKS)) u_en_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(off_req),
    .tick_i(tick_i), .done_o(en_done)
  );

  lsr_tick_timer #(.LIMIT(RST_TICKS)) u_hold_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!off_req),
    .tick_i(tick_i), .done_o(hold_done)
  );

  lsr_tick_timer #(.LIMIT(INIT_TICKS)) u_init_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(!in_init),
    .tick_i(tick_i), .done_o(init_done)
  );

  lsr_ctrl_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .off_req_i  (off_req),
    .fault_raw_i(drv_fault_i),
    .init_done_i(init_done),
    .hold_done_i(hold_done),
    .state_o    (state)
  );

  // request gating is combinational so shutdown needs no clock edge
  assign laser_on_o   = (state == ST_RUN) && !off_req && en_done;
  assign fault_flag_o = (state == ST_FAULT) || (state == ST_OFF);
  assign ready_o      = (state == ST_RUN);
endmodule

// File: rtl/laser_safety_ctrl_chk.sv
module laser_safety_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic laser_off_req_i,
  input logic laser_off_sw_i,
  input logic drv_fault_i,
  input logic pwr_good_i,
  input logic laser_on_o,
  input logic fault_flag_o,
  input logic ready_o
);
  a_r3_req_kills_laser: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (laser_off_req_i || laser_off_sw_i) |-> !laser_on_o);

  a_r1_power_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (fault_flag_o && !laser_on_o && !ready_o));

  a_r2_dark_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !laser_on_o);

  a_r5_fault_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && drv_fault_i && pwr_good_i) |=> (fault_flag_o && !ready_o && !laser_on_o));

  a_r6_clear_then_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fault_flag_o) && pwr_good_i) |-> (!laser_on_o && !ready_o));
endmodule

bind laser_safety_ctrl laser_safety_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .laser_off_req_i(laser_off_req_i),
  .laser_off_sw_i (laser_off_sw_i),
  .drv_fault_i    (drv_fault_i),
  .pwr_good_i     (pwr_good_i),
  .laser_on_o     (laser_on_o),
  .fault_flag_o   (fault_flag_o),
  .ready_o        (ready_o)
);

// File: tb/tb_laser_safety_ctrl.sv
`timescale 1ns/1ps
module tb_laser_safety_ctrl;
  localparam int RST  = 8;
  localparam int EN   = 5;
  localparam int INIT = 20;

  logic clk = 1'b0;
  logic rst_ni, tick, req, sw, flt, pg;
  logic laser_on, fault_flag, ready;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  laser_safety_ctrl #(.RST_TICKS(RST), .EN_TICKS(EN), .INIT_TICKS(INIT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .laser_off_req_i(req), .laser_off_sw_i(sw), .drv_fault_i(flt),
    .pwr_good_i(pg), .laser_on_o(laser_on), .fault_flag_o(fault_flag),
    .ready_o(ready)
  );

  typedef struct packed {
    logic       req;
    logic       sw;
    logic       exp_on;
    logic [7:0] edges;
  } vec_t;

  // R3 / R4 table, applied cumulatively from a running, lit state
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 1'b1, 8'd1},
    '{1'b1, 1'b0, 1'b0, 8'd0},
    '{1'b0, 1'b0, 1'b0, 8'(EN-1)},
    '{1'b0, 1'b0, 1'b1, 8'd1},
    '{1'b0, 1'b1, 1'b0, 8'd0},
    '{1'b0, 1'b1, 1'b0, 8'd3},
    '{1'b1, 1'b1, 1'b0, 8'd2},
    '{1'b0, 1'b0, 1'b1, 8'(EN)}
  };

  task automatic chk(input string req_tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req_tag, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; tick = 1'b1; req = 1'b1; sw = 1'b0; flt = 1'b0; pg = 1'b0;
    #1;
    chk("R1", "reset fault", fault_flag, 1'b1);
    chk("R1", "reset laser", laser_on, 1'b0);
    chk("R1", "reset ready", ready, 1'b0);
    edges(3);
    @(negedge clk) rst_ni = 1'b1;
    edges(3);
    chk("R1", "unpowered fault", fault_flag, 1'b1);

    // R2 power-up initialisation
    @(negedge clk) begin pg = 1'b1; req = 1'b0; end
    edges(1);
    chk("R2", "init fault low", fault_flag, 1'b0);
    chk("R2", "init ready", ready, 1'b0);
    edges(INIT);
    chk("R2", "last init cycle ready", ready, 1'b0);
    chk("R2", "last init cycle laser", laser_on, 1'b0);
    edges(1);
    chk("R2", "ready after init", ready, 1'b1);
    chk("R2", "laser after init", laser_on, 1'b1);

    // R3 / R4 table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin req = VEC[i].req; sw = VEC[i].sw; end
      if (VEC[i].edges == 0) #1;
      else edges(int'(VEC[i].edges));
      chk(VEC[i].edges == 0 ? "R3" : "R4", $sformatf("vector %0d laser", i),
          laser_on, VEC[i].exp_on);
    end

    // R8 timers only move on ticks
    @(negedge clk) req = 1'b1;
    edges(1);
    @(negedge clk) begin req = 1'b0; tick = 1'b0; end
    edges(20);
    chk("R8", "no ticks laser", laser_on, 1'b0);
    for (int i = 0; i < EN - 1; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    #1;
    chk("R8", "one tick short laser", laser_on, 1'b0);
    @(negedge clk) tick = 1'b1;
    @(posedge clk) #5;
    chk("R8", "final tick laser", laser_on, 1'b1);
    @(negedge clk) tick = 1'b1;

    // R5 fault latch
    @(negedge clk) flt = 1'b1;
    edges(1);
    chk("R5", "fault flag", fault_flag, 1'b1);
    chk("R5", "fault laser", laser_on, 1'b0);
    chk("R5", "fault ready", ready, 1'b0);
    @(negedge clk) flt = 1'b0;
    edges(10);
    chk("R5", "fault sticky", fault_flag, 1'b1);
    chk("R5", "laser stays off", laser_on, 1'b0);

    // R7 short pulse
    @(negedge clk) req = 1'b1;
    edges(RST - 1);
    @(negedge clk) req = 1'b0;
    edges(3);
    chk("R7", "short pulse keeps fault", fault_flag, 1'b1);

    // R6 valid clear then re-init
    @(negedge clk) req = 1'b1;
    edges(RST);
    @(negedge clk) req = 1'b0;
    edges(1);
    chk("R6", "fault cleared", fault_flag, 1'b0);
    chk("R6", "laser off at clear", laser_on, 1'b0);
    edges(INIT);
    chk("R6", "last reinit ready", ready, 1'b0);
    chk("R6", "last reinit laser", laser_on, 1'b0);
    edges(1);
    chk("R6", "ready restored", ready, 1'b1);
    chk("R6", "laser restored", laser_on, 1'b1);

    // R9 persisting fault relatches during re-init
    @(negedge clk) flt = 1'b1;
    edges(1);
    chk("R9", "fault set", fault_flag, 1'b1);
    @(negedge clk) req = 1'b1;
    edges(RST);
    @(negedge clk) req = 1'b0;
    edges(1);
    chk("R9", "cleared briefly", fault_flag, 1'b0);
    edges(1);
    chk("R9", "relatched", fault_flag, 1'b1);
    @(negedge clk) flt = 1'b0;

    // R1 power loss
    @(negedge clk) pg = 1'b0;
    edges(1);
    chk("R1", "power loss fault", fault_flag, 1'b1);
    chk("R1", "power loss laser", laser_on, 1'b0);
    chk("R1", "power loss ready", ready, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule